// File: doc/BRIEF.md
# Read-Once Boot Semaphore Register

This block is a 32-bit status word that lets several processors contend for the bootstrap role. While the block is armed, the first read returns a fixed non-zero signature. That read consumes the signature, and every later read returns zero. Whichever processor sees the signature becomes the bootstrap processor.

The word can be read on two ports: a configuration-space read port and a memory-mapped read port. Both ports share one armed flag, so a read on either port consumes the signature for both.

A synchronous reset arms the block. So does a one-cycle re-arm pulse, which comes from a control bit held elsewhere in the system. Read data is registered and comes back one cycle after the read strobe, together with a valid flag. The block has no write path, so a store aimed at this word cannot change it.

Top module: `boot_sem_reg`

## Requirements
- R1: After a synchronous active-high reset, the block is armed. The first read on either port returns 0x000000A5.
- R2: Once the signature has been returned, every later read on either port returns 0x00000000 until the block is re-armed or reset.
- R3: Bits 31:8 of both read data outputs are always zero.
- R4: The two ports share one armed state. A read on the memory-mapped port consumes the signature for the configuration port, and a read on the configuration port consumes it for the memory-mapped port.
- R5: When both ports read in the same cycle while armed, the configuration port receives 0x000000A5 and the memory-mapped port receives 0x00000000.
- R6: A one-cycle pulse on `rearm` restores the signature, so the next read returns 0x000000A5.
- R7: When `rearm` and a read occur in the same cycle, the read returns the value the block held before that cycle, and the block is still armed afterwards.
- R8: Each port's valid output is high in exactly the cycle after its read strobe was high. Read data is zero whenever valid is low, including after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; arms the block |
| cfgRdEn | input | 1 | Configuration-space read strobe (already address-selected) |
| mmioRdEn | input | 1 | Memory-mapped read strobe (already address-selected) |
| rearm | input | 1 | One-cycle pulse that restores the signature |
| cfgRdData | output | 32 | Configuration read data, one cycle after the strobe |
| cfgRdValid | output | 1 | Configuration read data valid |
| mmioRdData | output | 32 | Memory-mapped read data, one cycle after the strobe |
| mmioRdValid | output | 1 | Memory-mapped read data valid |

## Verification
Several properties are checked on every cycle:
- the reserved upper bits stay zero;
- the two ports never both return a non-zero word;
- valid follows its strobe with one cycle of latency, and data is zero when valid is low;
- the memory-mapped port gets zero whenever both ports read at once;
- two reads in a row without re-arm give zero on the second;
- a re-arm pulse followed by a configuration read gives the signature.

Some behaviour only the bench scenarios can show. These are the consumption that crosses between the two ports, the exact order of signature and zero across longer sequences with idle gaps, the outcome of a re-arm in the same cycle as a read from both the armed and the disarmed state, and re-arming by a mid-run reset.

// File: rtl/boot_sem_pkg.sv
package boot_sem_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic cfgAccept;   // configuration read captured this cycle
    logic mmioAccept;  // memory-mapped read captured this cycle
    logic sigToCfg;    // configuration port receives the signature
    logic sigToMmio;   // memory-mapped port receives the signature
    logic disarm;      // signature consumed this cycle
    logic rearm;       // restore the signature
  } semStrobes_t;

endpackage

// File: rtl/boot_sem_ctrl.sv
module boot_sem_ctrl
  import boot_sem_pkg::*;
(
  input  logic        cfgRdEn,
  input  logic        mmioRdEn,
  input  logic        rearmReq,
  input  logic        armed,
  output semStrobes_t strobes
);

  logic anyRead;

  always_comb begin
    anyRead           = cfgRdEn | mmioRdEn;
    strobes.cfgAccept  = cfgRdEn;
    strobes.mmioAccept = mmioRdEn;
    // Fixed priority: the configuration port wins a same-cycle tie.
    strobes.sigToCfg   = armed & cfgRdEn;
    strobes.sigToMmio  = armed & mmioRdEn & ~cfgRdEn;
    // A re-arm in the same cycle overrides consumption.
    strobes.rearm      = rearmReq;
    strobes.disarm     = armed & anyRead & ~rearmReq;
  end

endmodule

// File: rtl/boot_sem_dp.sv
module boot_sem_dp
  import boot_sem_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                SIG_W     = 8,
  parameter logic [SIG_W-1:0]  SIGNATURE = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  semStrobes_t       strobes,
  output logic              armed,
  output logic [DATA_W-1:0] cfgRdData,
  output logic              cfgRdValid,
  output logic [DATA_W-1:0] mmioRdData,
  output logic              mmioRdValid
);

  localparam int                PAD_W    = DATA_W - SIG_W;
  localparam logic [DATA_W-1:0] SIG_WORD = {{PAD_W{1'b0}}, SIGNATURE};

  logic [DATA_W-1:0] cfgNext;
  logic [DATA_W-1:0] mmioNext;

  always_comb begin
    cfgNext  = strobes.sigToCfg  ? SIG_WORD : '0;
    mmioNext = strobes.sigToMmio ? SIG_WORD : '0;
  end

  // Shared armed flag.
  always_ff @(posedge clk) begin
    if (rst)                 armed <= 1'b1;
    else if (strobes.rearm)  armed <= 1'b1;
    else if (strobes.disarm) armed <= 1'b0;
  end

  // Registered return stage for each port.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfgRdData   <= '0;
      cfgRdValid  <= 1'b0;
      mmioRdData  <= '0;
      mmioRdValid <= 1'b0;
    end else begin
      cfgRdData   <= cfgNext;
      cfgRdValid  <= strobes.cfgAccept;
      mmioRdData  <= mmioNext;
      mmioRdValid <= strobes.mmioAccept;
    end
  end

endmodule

// File: rtl/boot_sem_reg.sv
module boot_sem_reg
  import boot_sem_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter int               SIG_W     = 8,
  parameter logic [SIG_W-1:0] SIGNATURE = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgRdEn,
  input  logic              mmioRdEn,
  input  logic              rearm,
  output logic [DATA_W-1:0] cfgRdData,
  output logic              cfgRdValid,
  output logic [DATA_W-1:0] mmioRdData,
  output logic              mmioRdValid
);

  semStrobes_t strobes;
  logic        armed;

  boot_sem_ctrl u_ctrl (
    .cfgRdEn (cfgRdEn),
    .mmioRdEn(mmioRdEn),
    .rearmReq(rearm),
    .armed   (armed),
    .strobes (strobes)
  );

  boot_sem_dp #(
    .DATA_W   (DATA_W),
    .SIG_W    (SIG_W),
    .SIGNATURE(SIGNATURE)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .armed      (armed),
    .cfgRdData  (cfgRdData),
    .cfgRdValid (cfgRdValid),
    .mmioRdData (mmioRdData),
    .mmioRdValid(mmioRdValid)
  );

endmodule

// File: rtl/boot_sem_chk.sv
module boot_sem_chk #(
  parameter int               DATA_W    = 32,
  parameter int               SIG_W     = 8,
  parameter logic [SIG_W-1:0] SIGNATURE = 8'hA5
) (
  input logic              clk,
  input logic              rst,
  input logic              cfgRdEn,
  input logic              mmioRdEn,
  input logic              rearm,
  input logic [DATA_W-1:0] cfgRdData,
  input logic              cfgRdValid,
  input logic [DATA_W-1:0] mmioRdData,
  input logic              mmioRdValid
);

  localparam logic [DATA_W-1:0] SIG_WORD = {{(DATA_W-SIG_W){1'b0}}, SIGNATURE};

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (cfgRdData[DATA_W-1:SIG_W] == '0) && (mmioRdData[DATA_W-1:SIG_W] == '0));

  assert_single_winner_R4: assert property (@(posedge clk) disable iff (rst)
    !((cfgRdData != '0) && (mmioRdData != '0)));

  assert_tie_mmio_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (cfgRdEn && mmioRdEn) |=> (mmioRdData == '0));

  assert_second_read_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (cfgRdEn && !rearm) ##1 (cfgRdEn && !rearm) |=> (cfgRdData == '0));

  assert_rearm_restores_R6: assert property (@(posedge clk) disable iff (rst)
    rearm ##1 (cfgRdEn && !mmioRdEn) |=> (cfgRdData == SIG_WORD));

  assert_cfg_valid_R8: assert property (@(posedge clk) disable iff (rst)
    cfgRdEn |=> cfgRdValid);

  assert_cfg_novalid_R8: assert property (@(posedge clk) disable iff (rst)
    !cfgRdEn |=> !cfgRdValid);

  assert_mmio_valid_R8: assert property (@(posedge clk) disable iff (rst)
    mmioRdEn |=> mmioRdValid);

  assert_mmio_novalid_R8: assert property (@(posedge clk) disable iff (rst)
    !mmioRdEn |=> !mmioRdValid);

  assert_idle_data_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfgRdValid -> cfgRdData == '0) && (!mmioRdValid -> mmioRdData == '0));

endmodule

bind boot_sem_reg boot_sem_chk #(
  .DATA_W   (DATA_W),
  .SIG_W    (SIG_W),
  .SIGNATURE(SIGNATURE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfgRdEn    (cfgRdEn),
  .mmioRdEn   (mmioRdEn),
  .rearm      (rearm),
  .cfgRdData  (cfgRdData),
  .cfgRdValid (cfgRdValid),
  .mmioRdData (mmioRdData),
  .mmioRdValid(mmioRdValid)
);

// File: tb/boot_sem_reg_tb.sv
module boot_sem_reg_tb;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] SIGW       = 32'h0000_00A5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgRdEn = 1'b0;
  logic        mmioRdEn = 1'b0;
  logic        rearm = 1'b0;
  logic [31:0] cfgRdData;
  logic        cfgRdValid;
  logic [31:0] mmioRdData;
  logic        mmioRdValid;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  bit  modelArmed = 1'b1;

  logic [31:0] cfgQ[$];
  string       cfgTagQ[$];
  logic [31:0] mmioQ[$];
  string       mmioTagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_sem_reg u_dut (
    .clk        (clk),
    .rst        (rst),
    .cfgRdEn    (cfgRdEn),
    .mmioRdEn   (mmioRdEn),
    .rearm      (rearm),
    .cfgRdData  (cfgRdData),
    .cfgRdValid (cfgRdValid),
    .mmioRdData (mmioRdData),
    .mmioRdValid(mmioRdValid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the predicted results.
  task automatic drive(input bit c, input bit m, input bit r, input string req);
    @(negedge clk);
    cfgRdEn  = c;
    mmioRdEn = m;
    rearm    = r;
    if (c) begin
      cfgQ.push_back(modelArmed ? SIGW : 32'h0);
      cfgTagQ.push_back(req);
    end
    if (m) begin
      mmioQ.push_back((modelArmed && !c) ? SIGW : 32'h0);
      mmioTagQ.push_back(req);
    end
    if (r)           modelArmed = 1'b1;
    else if (c || m) modelArmed = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, "R8");
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; cfgRdEn = 1'b0; mmioRdEn = 1'b0; rearm = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    modelArmed = 1'b1;
    check(cfgRdValid === 1'b0 && cfgRdData === 32'h0, "R8", "cfg reset state",
          cfgRdData, 32'h0);
    check(mmioRdValid === 1'b0 && mmioRdData === 32'h0, "R8", "mmio reset state",
          mmioRdData, 32'h0);
  endtask

  // Monitor: pops the expected results as the outputs appear.
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (cfgQ.size() > 0) begin
        logic [31:0] e;
        string t;
        e = cfgQ.pop_front();
        t = cfgTagQ.pop_front();
        check(cfgRdValid === 1'b1, "R8", "cfg valid", {31'h0, cfgRdValid}, 32'h1);
        check(cfgRdData === e, t, "cfg data", cfgRdData, e);
        check(cfgRdData[31:8] === 24'h0, "R3", "cfg upper bits", cfgRdData, e);
      end else begin
        check(cfgRdValid === 1'b0 && cfgRdData === 32'h0, "R8", "cfg idle",
              cfgRdData, 32'h0);
      end
      if (mmioQ.size() > 0) begin
        logic [31:0] e;
        string t;
        e = mmioQ.pop_front();
        t = mmioTagQ.pop_front();
        check(mmioRdValid === 1'b1, "R8", "mmio valid", {31'h0, mmioRdValid}, 32'h1);
        check(mmioRdData === e, t, "mmio data", mmioRdData, e);
        check(mmioRdData[31:8] === 24'h0, "R3", "mmio upper bits", mmioRdData, e);
      end else begin
        check(mmioRdValid === 1'b0 && mmioRdData === 32'h0, "R8", "mmio idle",
              mmioRdData, 32'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: the first configuration read after reset wins.
    drive(1, 0, 0, "R1");
    // R2: later reads on both ports return zero.
    drive(1, 0, 0, "R2");
    idle(2);
    drive(0, 1, 0, "R2");
    // R6: a re-arm pulse, then a memory-mapped read gets the signature.
    drive(0, 0, 1, "R6");
    idle(1);
    drive(0, 1, 0, "R6");
    // R4: the memory-mapped read consumed it for the configuration port.
    drive(1, 0, 0, "R4");
    drive(0, 0, 1, "R6");
    drive(0, 1, 0, "R4");
    drive(1, 0, 0, "R4");
    // R5: a same-cycle tie while armed goes to the configuration port.
    drive(0, 0, 1, "R6");
    drive(1, 1, 0, "R5");
    drive(1, 1, 0, "R5");
    // R7: re-arm in the same cycle as a read from the disarmed state.
    drive(1, 0, 1, "R7");
    drive(1, 0, 0, "R7");
    // R7: re-arm in the same cycle as a read from the armed state.
    drive(0, 0, 1, "R6");
    drive(0, 1, 1, "R7");
    drive(1, 0, 0, "R7");
    drive(0, 1, 0, "R7");
    idle(3);
    // R1: a reset in the middle of a run re-arms the block.
    doReset();
    drive(0, 1, 0, "R1");
    drive(1, 1, 0, "R2");
    idle(3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule